// File: doc/BRIEF.md
# Codec Clock and Frame Timing Generator

This block derives every timing event a serial audio codec needs from one external master clock. Three dividers are chained. A master divider reduces the master clock by 1 to 5 to form an internal clock. A serial divider reduces that internal clock by 1, 2, 4 or 8 to form the serial bit clock. A sample divider counts internal-clock ticks to mark sample intervals of 256 to 2048 ticks. None of these is a gated clock. Each divided clock is a one-cycle enable in the master clock domain, so odd ratios stay glitch-free.

Each sample interval begins with a frame sync that stays high for one serial clock period. A DAC load strobe lands in a programmable position ahead of the next frame sync. With no advance, it lands one serial period before the frame sync. A 5-bit advance moves it earlier in fine steps of eight internal-clock ticks. The advance is captured only while the DAC section is disabled.

The divider control field is sampled at every serial clock falling edge, which is the serial enable. A new setting is held back until the current sample interval ends. Every counter then restarts under the new setting, so no interval is ever cut short.

Top module: `codec_tg_top`

## Requirements
- R1: A synchronous reset drives `dmclk_en`, `sclk_en` and `dac_load` low and `fsync` high. It selects master divide 1, serial divide 8 and sample length 2048, and it clears the latched advance to 0.
- R2: `ctrl[6:4]` codes 0, 1, 2, 3 and 4 make `dmclk_en` a one-cycle pulse every 1, 2, 3, 4 or 5 master clocks.
- R3: `ctrl[6:4]` codes 5, 6 and 7 give divide-by-one, the same as code 0.
- R4: `ctrl[3:2]` sets how many `dmclk_en` pulses make one serial period: code 0 gives 8, code 1 gives 4, code 2 gives 2 and code 3 gives 1. `sclk_en` is high only on the `dmclk_en` pulse that ends a serial period.
- R5: `ctrl[1:0]` sets the sample interval length N in `dmclk_en` pulses: code 0 gives 2048, code 1 gives 1024, code 2 gives 512 and code 3 gives 256. `fsync` rises in the cycle the interval starts and stays high for the first S internal ticks, where S is the serial divide.
- R6: `dac_load` is a one-cycle pulse, once per interval, coinciding with a `dmclk_en` pulse. With advance 0 it occurs exactly S·M master clocks before the next rising edge of `fsync`, where M is the master divide.
- R7: An advance value A moves `dac_load` 8·A internal ticks earlier. The pulse then occurs (S + 8·A)·M master clocks before the next rising edge of `fsync`.
- R8: `dac_adv` is latched on every clock while `dac_en` is low. While `dac_en` is high the latched value holds and changes on `dac_adv` have no effect.
- R9: `ctrl` is sampled on each `sclk_en` pulse. The most recent sample takes effect only at the end of the current sample interval, and all dividers restart from zero at that point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | External master clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl | input | 7 | Divider control: [6:4] master, [3:2] serial, [1:0] sample rate |
| dac_adv | input | 5 | DAC load advance in steps of 8 internal ticks |
| dac_en | input | 1 | DAC section enabled; freezes the latched advance |
| dmclk_en | output | 1 | Internal clock enable, one master cycle wide |
| sclk_en | output | 1 | Serial clock enable, marks the serial falling edge |
| fsync | output | 1 | Frame sync, high for the first serial period of each interval |
| dac_load | output | 1 | DAC load strobe, one master cycle wide |

## Verification
A wrong master count shows within five master clocks as a misplaced `dmclk_en` pulse. A wrong serial count shows within one serial period on `sclk_en`. A wrong sample count or latched setting may stay hidden until the next `fsync` rise, up to 10240 master clocks later. A corrupted advance shows only as a `dac_load` pulse in the wrong cycle, once per interval. The bench therefore compares all four outputs against a behavioural model on every clock. It also measures whole intervals and load-to-sync gaps directly across several divider settings.

// File: rtl/codec_tg_pkg.sv
package codec_tg_pkg;

  localparam int MDIV_CW  = 3;   // master divider counter width (ratio up to 5)
  localparam int SCK_LOG  = 3;   // log2 of slowest serial divide
  localparam int SMP_LOG  = 11;  // log2 of longest sample interval
  localparam int ADV_W    = 5;   // advance field width
  localparam int STEP_LOG = 3;   // log2 of internal ticks per advance step
  localparam int NW       = SMP_LOG + 1;

  typedef struct packed {
    logic [2:0] mdiv;
    logic [1:0] sdiv;
    logic [1:0] srate;
  } tg_ctrl_t;

  // master ratio minus one; reserved codes fall back to divide-by-one
  function automatic logic [MDIV_CW-1:0] mdiv_m1(input logic [2:0] code);
    return (code <= 3'd4) ? code : '0;
  endfunction

  function automatic logic [NW-1:0] serial_len(input logic [1:0] code);
    return NW'((1 << SCK_LOG) >> code);
  endfunction

  function automatic logic [NW-1:0] sample_len(input logic [1:0] code);
    return NW'((1 << SMP_LOG) >> code);
  endfunction

endpackage

// File: rtl/cg_mclk_div.sv
module cg_mclk_div #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] ratio_m1,
  output logic          tick
);
  logic [CW-1:0] cnt;

  assign tick = (cnt == ratio_m1);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R2: the phase counter never runs past the selected ratio
  a_r2_phase_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= ratio_m1);
endmodule

// File: rtl/cg_rate_div.sv
module cg_rate_div #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [CW-1:0] ratio_m1,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  assign wrap = step && (cnt == ratio_m1);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (wrap) cnt <= '0;
    else if (step) cnt <= cnt + 1'b1;
  end

  // R5: the count stays inside the selected length
  a_r5_count_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= ratio_m1);
endmodule

// File: rtl/cg_dac_sched.sv
module cg_dac_sched #(
  parameter int AW = 5,
  parameter int SW = 11,
  parameter int STEP_LOG = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dac_en,
  input  logic [AW-1:0] adv_in,
  input  logic [SW:0]   n_len,
  input  logic [SW:0]   s_len,
  output logic [SW-1:0] target
);
  logic [AW-1:0] adv_q;
  logic [SW:0]   lead;
  logic [SW:0]   land;

  always_ff @(posedge clk) begin
    if (rst)          adv_q <= '0;
    else if (!dac_en) adv_q <= adv_in;
  end

  assign lead   = s_len + ((SW+1)'(adv_q) << STEP_LOG);
  assign land   = n_len - lead;
  // count value just before the landing tick
  assign target = (land == '0) ? SW'(n_len - 1'b1) : SW'(land - 1'b1);

  // R8: an enabled DAC freezes the latched advance
  a_r8_adv_frozen: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dac_en)) |-> $stable(adv_q));
endmodule

// File: rtl/codec_tg_top.sv
module codec_tg_top
  import codec_tg_pkg::*;
#(
  parameter int ADV_WIDTH = ADV_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [6:0]           ctrl,
  input  logic [ADV_WIDTH-1:0] dac_adv,
  input  logic                 dac_en,
  output logic                 dmclk_en,
  output logic                 sclk_en,
  output logic                 fsync,
  output logic                 dac_load
);
  localparam int SCW = SCK_LOG;

  tg_ctrl_t        pend_q, act_q;
  logic            td, ts, bnd;
  logic [SCW-1:0]  scnt;
  logic [SMP_LOG-1:0] smp, smp_nxt, target;
  logic [NW-1:0]   s_len, n_len;
  logic            fsync_d, load_d;

  assign s_len = serial_len(act_q.sdiv);
  assign n_len = sample_len(act_q.srate);

  cg_mclk_div #(.CW(MDIV_CW)) i_mdiv (
    .clk(clk), .rst(rst), .ratio_m1(mdiv_m1(act_q.mdiv)), .tick(td));

  cg_rate_div #(.CW(SCW)) i_sdiv (
    .clk(clk), .rst(rst), .step(td),
    .ratio_m1(SCW'(s_len - 1'b1)), .cnt(scnt), .wrap(ts));

  cg_rate_div #(.CW(SMP_LOG)) i_smp (
    .clk(clk), .rst(rst), .step(td),
    .ratio_m1(SMP_LOG'(n_len - 1'b1)), .cnt(smp), .wrap(bnd));

  cg_dac_sched #(.AW(ADV_WIDTH), .SW(SMP_LOG), .STEP_LOG(STEP_LOG)) i_sched (
    .clk(clk), .rst(rst), .dac_en(dac_en), .adv_in(dac_adv),
    .n_len(n_len), .s_len(s_len), .target(target));

  assign smp_nxt = bnd ? '0 : (td ? smp + 1'b1 : smp);
  assign fsync_d = ({1'b0, smp_nxt} < s_len);
  assign load_d  = td && (smp == target);

  // control: sampled on serial edges, applied at interval end
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      if (bnd) act_q  <= pend_q;
      if (ts)  pend_q <= tg_ctrl_t'(ctrl);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dmclk_en <= 1'b0;
      sclk_en  <= 1'b0;
      fsync    <= 1'b1;
      dac_load <= 1'b0;
    end else begin
      dmclk_en <= td;
      sclk_en  <= ts;
      fsync    <= fsync_d;
      dac_load <= load_d;
    end
  end

  // R1: reset state of the outputs
  a_r1_reset_outputs: assert property (@(posedge clk)
    $past(rst) |-> (fsync && !dmclk_en && !sclk_en && !dac_load));
  // R4: serial edges only on internal ticks
  a_r4_sclk_on_tick: assert property (@(posedge clk) disable iff (rst)
    sclk_en |-> dmclk_en);
  // R6: load strobe only on internal ticks
  a_r6_load_on_tick: assert property (@(posedge clk) disable iff (rst)
    dac_load |-> dmclk_en);
  // R5: an interval starts on an internal tick that is also a serial edge
  a_r5_sync_start: assert property (@(posedge clk) disable iff (rst)
    $rose(fsync) |-> (dmclk_en && sclk_en));
  // R9: settings change only where a new interval begins
  a_r9_apply_at_boundary: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(act_q)) |-> $rose(fsync));
endmodule

// File: tb/test_codec_tg_top.sv
module test_codec_tg_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] ctrl = '0;
  logic [4:0] dac_adv = '0;
  logic       dac_en = 1'b0;
  logic       dmclk_en, sclk_en, fsync, dac_load;

  int nchk = 0, nerr = 0;

  always #10 clk = ~clk;  // 50 MHz

  codec_tg_top i_codec_tg_top (
    .clk(clk), .rst(rst), .ctrl(ctrl), .dac_adv(dac_adv), .dac_en(dac_en),
    .dmclk_en(dmclk_en), .sclk_en(sclk_en), .fsync(fsync), .dac_load(dac_load));

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model, from the requirements
  int mc, dc, act_c, pend_c, adv_m;
  bit e_dm, e_sc, e_fs = 1'b1, e_dl;

  function automatic int mratio(input int c);
    return (c <= 4) ? c + 1 : 1;  // R2 R3
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mc = 0; dc = 0; act_c = 0; pend_c = 0; adv_m = 0;
      e_dm = 0; e_sc = 0; e_dl = 0; e_fs = 1;
    end else begin
      int m, s, n, land;
      bit td, ts, bnd;
      m = mratio((act_c >> 4) & 7);
      s = 8 >> ((act_c >> 2) & 3);
      n = 2048 >> (act_c & 3);
      td = (mc == m - 1);
      ts = td && (dc % s == s - 1);
      bnd = td && (dc == n - 1);
      land = n - s - 8 * adv_m;
      e_dm = td; e_sc = ts;
      e_dl = td && (((dc + 1) % n) == land);
      if (td) begin mc = 0; dc = (dc + 1) % n; end
      else mc = mc + 1;
      e_fs = (dc < s);
      if (bnd) act_c = pend_c;
      if (ts) pend_c = int'(ctrl);
      if (!dac_en) adv_m = int'(dac_adv);
    end
  end

  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk("R2 R3 dmclk_en", int'(dmclk_en), int'(e_dm));
      chk("R4 sclk_en", int'(sclk_en), int'(e_sc));
      chk("R5 R9 fsync", int'(fsync), int'(e_fs));
      chk("R6 R7 R8 dac_load", int'(dac_load), int'(e_dl));
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic interval(input int exp, input string tag);
    bit p;
    int n = 0;
    p = fsync;
    while (!(fsync && !p)) begin p = fsync; @(negedge clk); end
    p = fsync;
    do begin @(negedge clk); n++; if (fsync && !p) break; p = fsync; end while (1);
    chk(tag, n, exp);
  endtask

  task automatic load_gap(input int exp, input string tag);
    bit p;
    int n = 0;
    while (!dac_load) @(negedge clk);
    p = fsync;
    do begin @(negedge clk); n++; if (fsync && !p) break; p = fsync; end while (1);
    chk(tag, n, exp);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    run(4);
    @(negedge clk);
    // R1: reset state
    chk("R1 dmclk_en", int'(dmclk_en), 0);
    chk("R1 sclk_en", int'(sclk_en), 0);
    chk("R1 fsync", int'(fsync), 1);
    chk("R1 dac_load", int'(dac_load), 0);
    rst = 1'b0;
    cmp_on = 1;
    run(100);
    interval(2048, "R1 R5 default interval");
    load_gap(8, "R1 R6 default load gap");
    dac_adv = 5'd3; run(2); dac_en = 1'b1;
    run(4200);
    load_gap(32, "R7 advance 3");
    dac_adv = 5'd20;  // R8: ignored while enabled
    run(4200);
    load_gap(32, "R8 advance held");
    ctrl = 7'h4E;
    run(4200 + 2600);
    interval(2560, "R2 R5 div5 len512");
    load_gap(125, "R7 div5 ser1 adv3");
    dac_en = 1'b0; dac_adv = 5'd31; run(2); dac_en = 1'b1;
    ctrl = 7'h3F;
    run(5300);
    interval(1024, "R2 R5 div4 len256");
    load_gap(996, "R7 advance 31");
    ctrl = 7'h73;
    run(2200);
    interval(256, "R3 code7 len256");
    load_gap(256, "R7 load at interval start");
    ctrl = 7'h56;
    run(1200);
    interval(512, "R3 code5 len512");
    load_gap(252, "R4 R7 serial4 adv31");
    ctrl = 7'h2B;
    run(1200);
    interval(768, "R2 div3 len256");
    load_gap(750, "R4 R7 serial2 adv31");
    ctrl = 7'h61;
    run(2200);
    interval(1024, "R3 code6 len1024");
    summary();
    $finish;
  end
endmodule